// File: doc/BRIEF.md
# Trap Entry Selector

This block sits between the exception detector of a processor core and its trap state save logic. When a trap is raised it looks at the current trap depth, the privilege flags and the reset/error flag, and decides which kind of entry the trap takes. The possible entries are a reset-error (RED) entry, a guest-watchdog escalation, a hyperprivileged entry, a privileged entry, or an error condition that has no vector at all.

For the chosen entry it forms the handler address from the matching base register, then the two sequential fetch addresses after it. It also raises a flag that tells the save unit whether the new mode is hyperprivileged. All results are captured on the cycle that carries the trap strobe, and they are held until the next strobe.

A two-state machine tracks whether a fresh result is on the outputs. The states are `ST_IDLE` (nothing new) and `ST_SHOW` (result captured at the last edge). The transitions are:
- IDLE→SHOW on a strobe.
- SHOW→SHOW on a back-to-back strobe.
- SHOW→IDLE when the strobe is low.
- IDLE→IDLE when the strobe is low.

Top module: `trapvec_sel`

## Requirements
- R1: After reset `out_valid` is 0. `out_entry`, `out_vec_tt`, `go_hyper`, `handler_pc`, `handler_npc` and `handler_nnpc` are all 0.
- R2: A result is captured at every rising edge where `trap_valid` is 1, and `out_valid` is 1 in the cycle after that edge. When `trap_valid` is 0, `out_valid` goes to 0 after the edge and every other output keeps its value, whatever the other inputs do.
- R3: If `st_red` is 1 or `cur_tl` equals MAX_TL-1 (5), the entry is RED (code 0) with vector type 5. `handler_pc` = 0xFFF0000000 | ((5<<5) & 0xFF) = 0xFFF00000A0. This check has the highest priority.
- R4: Otherwise, if `cur_tl` is MAX_TL (6) or above, the entry is ERROR (code 4). `out_vec_tt`, `go_hyper` and all three addresses are 0.
- R5: The current level is hyperprivileged when `st_hpriv` is 1, otherwise privileged when `st_priv` is 1, otherwise user. The next level is one step above the current level, capped at hyperprivileged.
- R6: Otherwise, if `cur_tl` > MAX_PTL (2) and the next level is privileged, the entry is guest watchdog (code 2). It uses vector type 2 and the hyperprivileged address format.
- R7: Otherwise, if the next level is hyperprivileged, or the trap type is at least 384 (0x180), the entry is hyperprivileged (code 1) and the vector type is the trap type.
- R8: In every remaining case the entry is privileged (code 3) and the vector type is the trap type.
- R9: The hyperprivileged address format (codes 1 and 2) is `htba` with bits 13:0 cleared, ORed with (vector type << 5) kept to 14 bits.
- R10: The privileged address format (code 3) is `tba` with bits 14:0 cleared, ORed with bit 14 when `cur_tl`+1 > 1, and ORed with (trap type << 5) kept to 14 bits.
- R11: For every entry other than ERROR, `handler_npc` = `handler_pc`+4 and `handler_nnpc` = `handler_pc`+8.
- R12: `go_hyper` is 1 for entry codes 0, 1 and 2, and 0 for codes 3 and 4.
- R13: `out_vec_tt` is the vector type used for the address: 5 for RED, 2 for guest watchdog, the trap type for codes 1 and 3, and 0 for ERROR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap strobe; inputs are captured while high |
| trap_type | input | 9 | Incoming trap type |
| cur_tl | input | 3 | Current trap level |
| st_priv | input | 1 | Privileged-mode flag |
| st_hpriv | input | 1 | Hyperprivileged-mode flag |
| st_red | input | 1 | Reset/error-state flag |
| tba | input | 64 | Privileged trap base address |
| htba | input | 64 | Hyperprivileged trap base address |
| out_valid | output | 1 | Fresh result on the outputs |
| out_entry | output | 3 | Entry code: 0 RED, 1 hyper, 2 watchdog, 3 priv, 4 error |
| out_vec_tt | output | 9 | Vector type used for the address |
| go_hyper | output | 1 | New mode is hyperprivileged |
| handler_pc | output | 64 | Handler address |
| handler_npc | output | 64 | Handler address + 4 |
| handler_nnpc | output | 64 | Handler address + 8 |

## Verification
The bench sweeps every trap level from 0 to 7 against all eight flag combinations and ten trap types. The trap types straddle the 384 threshold and include values whose high bits spill past the RED index mask.

- If the priority were wrong, a flagged-RED trap at level 6 would be reported as an error, or a watchdog case would become a plain privileged entry.
- If the privileged format dropped the depth bit, level-0 and level-1 traps would land on the same handler.
- If the hyperprivileged format forgot to clear the base's low bits, the garbage bits in the supplied `htba` would show in the address.
- A final phase changes every input with the strobe low. A design that does not hold its outputs would show that change.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_PRIV  = 2'd1,
        LVL_HYPER = 2'd2
    } lvl_e;

    typedef enum logic [2:0] {
        ENTRY_RED   = 3'd0,
        ENTRY_HYPER = 3'd1,
        ENTRY_WDOG  = 3'd2,
        ENTRY_PRIV  = 3'd3,
        ENTRY_ERROR = 3'd4
    } entry_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } fsm_e;

endpackage

// File: rtl/trapvec_level.sv
module trapvec_level
    import trapvec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic st_priv,
    input  logic st_hpriv,
    output lvl_e nxt_lvl
);

    lvl_e cur_lvl;

    always_comb begin
        if (st_hpriv)     cur_lvl = LVL_HYPER;
        else if (st_priv) cur_lvl = LVL_PRIV;
        else              cur_lvl = LVL_USER;
    end

    always_comb begin
        unique case (cur_lvl)
            LVL_USER:  nxt_lvl = LVL_PRIV;
            LVL_PRIV:  nxt_lvl = LVL_HYPER;
            LVL_HYPER: nxt_lvl = LVL_HYPER;
            default:   nxt_lvl = LVL_HYPER;
        endcase
    end

    assert_hpriv_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_hpriv |-> nxt_lvl == LVL_HYPER);
    assert_priv_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_priv && !st_hpriv) |-> nxt_lvl == LVL_HYPER);
    assert_user_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_priv && !st_hpriv) |-> nxt_lvl == LVL_PRIV);

endmodule

// File: rtl/trapvec_route.sv
module trapvec_route
    import trapvec_pkg::*;
#(
    parameter int TL_W         = 3,
    parameter int TT_W         = 9,
    parameter int MAX_TL       = 6,
    parameter int MAX_PTL      = 2,
    parameter int HYPER_TT_MIN = 384,
    parameter int RED_TT       = 5,
    parameter int WDOG_TT      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TL_W-1:0]   cur_tl,
    input  logic              st_red,
    input  lvl_e              nxt_lvl,
    input  logic [TT_W-1:0]   trap_type,
    output entry_e            entry,
    output logic [TT_W-1:0]   vec_tt,
    output logic [TL_W:0]     new_tl
);

    localparam logic [TL_W-1:0] TL_RED  = TL_W'(MAX_TL - 1);
    localparam logic [TL_W-1:0] TL_ERR  = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0] TL_PMAX = TL_W'(MAX_PTL);
    localparam logic [TT_W-1:0] TT_HMIN = TT_W'(HYPER_TT_MIN);
    localparam logic [TT_W-1:0] TT_RED  = TT_W'(RED_TT);
    localparam logic [TT_W-1:0] TT_WDOG = TT_W'(WDOG_TT);

    always_comb begin
        entry  = ENTRY_PRIV;
        vec_tt = trap_type;
        if (st_red || cur_tl == TL_RED) begin
            entry  = ENTRY_RED;
            vec_tt = TT_RED;
        end else if (cur_tl >= TL_ERR) begin
            entry  = ENTRY_ERROR;
            vec_tt = '0;
        end else if (cur_tl > TL_PMAX && nxt_lvl == LVL_PRIV) begin
            entry  = ENTRY_WDOG;
            vec_tt = TT_WDOG;
        end else if (nxt_lvl == LVL_HYPER || trap_type >= TT_HMIN) begin
            entry  = ENTRY_HYPER;
        end
    end

    assign new_tl = {1'b0, cur_tl} + {{TL_W{1'b0}}, 1'b1};

    assert_err_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        entry == ENTRY_ERROR |-> (cur_tl >= TL_ERR && !st_red));
    assert_red_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_red |-> entry == ENTRY_RED);
    assert_wdog_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        entry == ENTRY_WDOG |-> (vec_tt == TT_WDOG && nxt_lvl == LVL_PRIV));
    assert_priv_low_tt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        entry == ENTRY_PRIV |-> (trap_type < TT_HMIN && nxt_lvl == LVL_PRIV));

endmodule

// File: rtl/trapvec_addr.sv
module trapvec_addr
    import trapvec_pkg::*;
#(
    parameter int                ADDR_W      = 64,
    parameter int                TT_W        = 9,
    parameter int                TL_W        = 3,
    parameter logic [ADDR_W-1:0] RED_BASE    = ADDR_W'(64'h0000_00FF_F000_0000),
    parameter int                HVEC_LOW    = 14,
    parameter int                PVEC_LOW    = 15,
    parameter int                ENTRY_SHIFT = 5,
    parameter int                RED_IDX_W   = 8,
    parameter int                INSN_BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  entry_e            entry,
    input  logic [TT_W-1:0]   vec_tt,
    input  logic [TL_W:0]     new_tl,
    input  logic [ADDR_W-1:0] tba,
    input  logic [ADDR_W-1:0] htba,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] npc,
    output logic [ADDR_W-1:0] nnpc
);

    localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] HMASK   = (ONE << HVEC_LOW) - ONE;
    localparam logic [ADDR_W-1:0] PMASK   = (ONE << PVEC_LOW) - ONE;
    localparam logic [ADDR_W-1:0] RMASK   = (ONE << RED_IDX_W) - ONE;
    localparam logic [ADDR_W-1:0] DEEPBIT = ONE << HVEC_LOW;
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(INSN_BYTES);
    localparam logic [TL_W:0]     TL_ONE  = (TL_W+1)'(1);

    logic [ADDR_W-1:0] tt_off;
    logic [ADDR_W-1:0] red_pc, hyp_pc, priv_pc;

    assign tt_off  = ADDR_W'(vec_tt) << ENTRY_SHIFT;
    assign red_pc  = RED_BASE | (tt_off & RMASK);
    assign hyp_pc  = (htba & ~HMASK) | (tt_off & HMASK);
    assign priv_pc = (tba & ~PMASK) | ((new_tl > TL_ONE) ? DEEPBIT : '0)
                   | (tt_off & HMASK);

    always_comb begin
        unique case (entry)
            ENTRY_RED:               pc = red_pc;
            ENTRY_HYPER, ENTRY_WDOG: pc = hyp_pc;
            ENTRY_PRIV:              pc = priv_pc;
            default:                 pc = '0;
        endcase
        if (entry == ENTRY_ERROR) begin
            npc  = '0;
            nnpc = '0;
        end else begin
            npc  = pc + STEP;
            nnpc = pc + STEP + STEP;
        end
    end

    assert_slot_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        entry != ENTRY_ERROR |-> pc[ENTRY_SHIFT-1:0] == '0);
    assert_hyp_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (entry == ENTRY_HYPER || entry == ENTRY_WDOG)
            |-> pc[ADDR_W-1:HVEC_LOW] == htba[ADDR_W-1:HVEC_LOW]);
    assert_priv_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
        entry == ENTRY_PRIV |-> pc[ADDR_W-1:PVEC_LOW] == tba[ADDR_W-1:PVEC_LOW]);

endmodule

// File: rtl/trapvec_sel.sv
module trapvec_sel
    import trapvec_pkg::*;
#(
    parameter int ADDR_W       = 64,
    parameter int TT_W         = 9,
    parameter int TL_W         = 3,
    parameter int MAX_TL       = 6,
    parameter int MAX_PTL      = 2,
    parameter int HYPER_TT_MIN = 384,
    parameter int RED_TT       = 5,
    parameter int WDOG_TT      = 2,
    parameter int HVEC_LOW     = 14,
    parameter int PVEC_LOW     = 15,
    parameter int ENTRY_SHIFT  = 5,
    parameter int RED_IDX_W    = 8,
    parameter int INSN_BYTES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid,
    input  logic [TT_W-1:0]   trap_type,
    input  logic [TL_W-1:0]   cur_tl,
    input  logic              st_priv,
    input  logic              st_hpriv,
    input  logic              st_red,
    input  logic [ADDR_W-1:0] tba,
    input  logic [ADDR_W-1:0] htba,
    output logic              out_valid,
    output logic [2:0]        out_entry,
    output logic [TT_W-1:0]   out_vec_tt,
    output logic              go_hyper,
    output logic [ADDR_W-1:0] handler_pc,
    output logic [ADDR_W-1:0] handler_npc,
    output logic [ADDR_W-1:0] handler_nnpc
);

    lvl_e              nxt_lvl;
    entry_e            entry;
    logic [TT_W-1:0]   vec_tt;
    logic [TL_W:0]     new_tl;
    logic [ADDR_W-1:0] pc_c, npc_c, nnpc_c;
    logic              hyp_c;
    fsm_e              state_q, state_d;

    trapvec_level u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_priv  (st_priv),
        .st_hpriv (st_hpriv),
        .nxt_lvl  (nxt_lvl)
    );

    trapvec_route #(
        .TL_W(TL_W), .TT_W(TT_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL),
        .HYPER_TT_MIN(HYPER_TT_MIN), .RED_TT(RED_TT), .WDOG_TT(WDOG_TT)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_tl    (cur_tl),
        .st_red    (st_red),
        .nxt_lvl   (nxt_lvl),
        .trap_type (trap_type),
        .entry     (entry),
        .vec_tt    (vec_tt),
        .new_tl    (new_tl)
    );

    trapvec_addr #(
        .ADDR_W(ADDR_W), .TT_W(TT_W), .TL_W(TL_W),
        .HVEC_LOW(HVEC_LOW), .PVEC_LOW(PVEC_LOW), .ENTRY_SHIFT(ENTRY_SHIFT),
        .RED_IDX_W(RED_IDX_W), .INSN_BYTES(INSN_BYTES)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .entry  (entry),
        .vec_tt (vec_tt),
        .new_tl (new_tl),
        .tba    (tba),
        .htba   (htba),
        .pc     (pc_c),
        .npc    (npc_c),
        .nnpc   (nnpc_c)
    );

    always_comb begin
        unique case (entry)
            ENTRY_RED, ENTRY_HYPER, ENTRY_WDOG: hyp_c = 1'b1;
            default:                            hyp_c = 1'b0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = trap_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = trap_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_entry    <= 3'd0;
            out_vec_tt   <= '0;
            go_hyper     <= 1'b0;
            handler_pc   <= '0;
            handler_npc  <= '0;
            handler_nnpc <= '0;
        end else if (trap_valid) begin
            out_entry    <= entry;
            out_vec_tt   <= vec_tt;
            go_hyper     <= hyp_c;
            handler_pc   <= pc_c;
            handler_npc  <= npc_c;
            handler_nnpc <= nnpc_c;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> out_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !out_valid);
    assert_hold_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> ($stable(handler_pc) && $stable(out_entry)));
    assert_red_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && st_red) |=> (out_entry == 3'd0 && go_hyper));
    assert_err_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_entry == 3'd4) |-> (handler_pc == '0 && !go_hyper));
    assert_seq_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_entry != 3'd4)
            |-> (handler_npc == handler_pc + ADDR_W'(INSN_BYTES)
                 && handler_nnpc == handler_npc + ADDR_W'(INSN_BYTES)));

endmodule

// File: tb/sim_trapvec_sel.sv
module sim_trapvec_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic [8:0]  trap_type = '0;
    logic [2:0]  cur_tl = '0;
    logic        st_priv = 1'b0, st_hpriv = 1'b0, st_red = 1'b0;
    logic [63:0] tba = '0, htba = '0;
    logic        out_valid;
    logic [2:0]  out_entry;
    logic [8:0]  out_vec_tt;
    logic        go_hyper;
    logic [63:0] handler_pc, handler_npc, handler_nnpc;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    trapvec_sel u0 (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_type(trap_type),
        .cur_tl(cur_tl), .st_priv(st_priv), .st_hpriv(st_hpriv), .st_red(st_red),
        .tba(tba), .htba(htba), .out_valid(out_valid), .out_entry(out_entry),
        .out_vec_tt(out_vec_tt), .go_hyper(go_hyper), .handler_pc(handler_pc),
        .handler_npc(handler_npc), .handler_nnpc(handler_nnpc)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] tt_pick(input int i);
        case (i)
            0: return 9'h001;  1: return 9'h005;  2: return 9'h024;
            3: return 9'h07F;  4: return 9'h0A3;  5: return 9'h100;
            6: return 9'h17F;  7: return 9'h180;  8: return 9'h1C5;
            default: return 9'h1FF;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog R2 actual=%0d expected=<100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic drive(input int tl, input int fl, input int ti, input bit v);
        @(negedge clk);
        trap_valid = v;
        cur_tl     = 3'(tl);
        st_red     = fl[2];
        st_hpriv   = fl[1];
        st_priv    = fl[0];
        trap_type  = tt_pick(ti);
        tba        = ti[0] ? 64'h0000_1234_5678_FFFF : 64'hABCD_0000_9999_7A55;
        htba       = ti[0] ? 64'hFEDC_BA98_7654_FFFF : 64'h0000_0042_0000_2003;
    endtask

    task automatic verify_trap(input int tl, input int fl, input int ti);
        logic [8:0]  tt;
        logic [63:0] tb_a, hb_a, epc;
        int cur, nxt, kind, vtt;
        string ktag;
        tt   = tt_pick(ti);
        tb_a = ti[0] ? 64'h0000_1234_5678_FFFF : 64'hABCD_0000_9999_7A55;
        hb_a = ti[0] ? 64'hFEDC_BA98_7654_FFFF : 64'h0000_0042_0000_2003;
        cur  = fl[1] ? 2 : (fl[0] ? 1 : 0);      // R5 level ordering
        nxt  = (cur == 0) ? 1 : 2;
        if (fl[2] || tl == 5) begin
            kind = 0; vtt = 5; epc = 64'hFF_F000_0000 | ((64'd5 << 5) & 64'hFF); ktag = "R3";
        end else if (tl >= 6) begin
            kind = 4; vtt = 0; epc = 0; ktag = "R4";
        end else if (tl > 2 && nxt == 1) begin
            kind = 2; vtt = 2; epc = (hb_a & ~64'h3FFF) | (64'd2 << 5); ktag = "R6";
        end else if (nxt == 2 || tt >= 9'd384) begin
            kind = 1; vtt = int'(tt);
            epc = (hb_a & ~64'h3FFF) | ((64'(tt) << 5) & 64'h3FFF); ktag = "R7";
        end else begin
            kind = 3; vtt = int'(tt);
            epc = (tb_a & ~64'h7FFF) | ((tl + 1 > 1) ? 64'h4000 : 64'h0)
                | ((64'(tt) << 5) & 64'h3FFF); ktag = "R8";
        end
        chk({ktag, " entry (R5 level)"}, 64'(out_entry), 64'(kind));
        chk("R13 vector type", 64'(out_vec_tt), 64'(vtt));
        chk((kind == 3) ? "R10 priv pc" : ((kind == 1 || kind == 2) ? "R9 hyper pc" : {ktag, " pc"}),
            handler_pc, epc);
        chk("R11 npc", handler_npc, (kind == 4) ? 64'h0 : epc + 64'd4);
        chk("R11 nnpc", handler_nnpc, (kind == 4) ? 64'h0 : epc + 64'd8);
        chk("R12 go_hyper", 64'(go_hyper), (kind <= 2) ? 64'h1 : 64'h0);
        chk("R2 valid after strobe", 64'(out_valid), 64'h1);
    endtask

    initial begin
        logic [63:0] held_pc;
        logic [2:0]  held_entry;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset valid", 64'(out_valid), 64'h0);
        chk("R1 reset pc", handler_pc, 64'h0);
        chk("R1 reset npc", handler_npc, 64'h0);
        chk("R1 reset nnpc", handler_nnpc, 64'h0);
        chk("R1 reset entry", 64'(out_entry), 64'h0);
        chk("R1 reset hyper", 64'(go_hyper), 64'h0);
        chk("R1 reset vec", 64'(out_vec_tt), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // back-to-back sweep: strobe stays high across every case
        for (int tl = 0; tl < 8; tl++) begin
            for (int fl = 0; fl < 8; fl++) begin
                for (int ti = 0; ti < 10; ti++) begin
                    drive(tl, fl, ti, 1'b1);
                    @(posedge clk);
                    #2;
                    verify_trap(tl, fl, ti);
                end
            end
        end

        // R2: drop strobe, outputs hold while inputs move
        held_pc    = handler_pc;
        held_entry = out_entry;
        for (int k = 0; k < 4; k++) begin
            drive(k, k, k + 3, 1'b0);
            @(posedge clk);
            #2;
            chk("R2 valid low", 64'(out_valid), 64'h0);
            chk("R2 pc held", handler_pc, held_pc);
            chk("R2 entry held", 64'(out_entry), 64'(held_entry));
        end

        // R2: single strobe after idle
        drive(0, 0, 0, 1'b1);
        @(posedge clk);
        #2;
        verify_trap(0, 0, 0);
        drive(0, 0, 0, 1'b0);
        @(posedge clk);
        #2;
        chk("R2 single pulse ends", 64'(out_valid), 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule